// File: doc/BRIEF.md
# Interrupt Source Coalescing State Array

This block keeps a two-bit state for every interrupt source and uses it to decide whether a hardware trigger from that source goes on to the routing stage. The two bits are P (bit 1, pending) and Q (bit 0, queued). A trigger that finds a source idle is forwarded and marks the source pending. Further triggers that arrive while the source is pending are folded into the queued bit and are not forwarded. This keeps the routing stage from being flooded. The combination P=0, Q=1 marks a source that is switched off.

Software reaches the state through a load/store port addressed by a source number and a three-bit operation offset. Depending on the offset, a load can read the state, replace it and return the old value, or perform an end-of-interrupt. A store can perform an end-of-interrupt or inject a trigger. An end-of-interrupt on a source that collected a trigger while it was pending sends that event again on a separate notification lane. Both notification lanes and the read data are registered, so each appears one clock after its cause.

Top module: `evsrc_pq_array`

## Requirements
- R1: A synchronous active-high reset puts every source in state 01 (off) and clears every output. After reset, a load at offset 000 of any source returns 01 and a trigger to it forwards nothing.
- R2: A hardware trigger to a source in state 00 moves it to 10. One cycle later it raises `hw_ntf_valid` with `hw_ntf_src` equal to the trigger's source, for every source number up to the highest.
- R3: A hardware trigger to a source in state 10 moves it to 11, and one to a source in state 11 leaves it at 11. Neither forwards anything.
- R4: A hardware trigger to a source in state 01 leaves it at 01 and forwards nothing.
- R5: Offset 001 is end-of-interrupt, by load or by store.
  - It takes 10 to 00 and 11 to 10.
  - For 11 it raises `sw_ntf_valid` with `sw_ntf_src` equal to the addressed source one cycle later.
  - States 00 and 01 are left unchanged and forward nothing.
- R6: Every load returns, one cycle later on `rd_valid`/`rd_data`, the addressed source's state as it stood before the operation. A load at offset 000 changes nothing.
- R7: A load at offset 1pq returns the old state and writes pq (bit 1 of the offset is P, bit 0 is Q). It never forwards.
- R8: A store at offset 010 acts as a trigger on the addressed source, with the transitions of R2 to R4. A forward it causes appears on the software lane (`sw_ntf_valid`).
- R9: The following change no state, forward nothing and return no read data:
  - stores at offsets 000, 011 and 1xx.
  
  Loads at offsets 010 and 011 return the state without changing it.
- R10: When a hardware trigger and a port operation address the same source in one cycle, the port operation is applied first. The trigger then acts on the resulting state.
- R11: A hardware trigger and a port operation on different sources in one cycle are both applied. Both notification lanes may be raised in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_valid | input | 1 | Hardware trigger strobe |
| trig_src | input | SRC_W | Source number of the trigger |
| mm_valid | input | 1 | Port operation strobe |
| mm_write | input | 1 | 1 = store, 0 = load |
| mm_src | input | SRC_W | Source addressed by the operation |
| mm_op | input | 3 | Operation offset |
| rd_valid | output | 1 | Load data valid, one cycle after the load |
| rd_data | output | 2 | Pre-operation PQ of the loaded source |
| hw_ntf_valid | output | 1 | Notification caused by a hardware trigger |
| hw_ntf_src | output | SRC_W | Source of the hardware-lane notification |
| sw_ntf_valid | output | 1 | Notification caused by a port operation |
| sw_ntf_src | output | SRC_W | Source of the software-lane notification |

## Verification
A wrong state bit shows up in two ways. A load returns a wrong value one cycle later. Or a later trigger or end-of-interrupt forwards when it should hold back, or holds back when it should forward. The stimulus therefore runs each source through every transition and reads back the state right after each one. That way a fault becomes visible within one or two cycles rather than after a long chain of events. The same-cycle cases check the order in which the port operation and the trigger are applied to a source. They also check that the two lanes never report the same source together.

// File: rtl/evsrc_pq_pkg.sv
package evsrc_pq_pkg;

    localparam int OP_W = 3;

    typedef logic [1:0] pq_t;

    localparam pq_t PQ_IDLE   = 2'b00;
    localparam pq_t PQ_OFF    = 2'b01;
    localparam pq_t PQ_PEND   = 2'b10;
    localparam pq_t PQ_QUEUED = 2'b11;

    localparam logic [OP_W-1:0] OFS_GET  = 3'b000;
    localparam logic [OP_W-1:0] OFS_EOI  = 3'b001;
    localparam logic [OP_W-1:0] OFS_TRIG = 3'b010;

    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_PEEK,
        KIND_EOI,
        KIND_TRIG,
        KIND_SET
    } op_kind_e;

    typedef struct packed {
        logic     is_load;
        op_kind_e kind;
        pq_t      set_val;
    } mm_cmd_t;

    typedef struct packed {
        pq_t  nxt;
        logic fwd;
    } pq_step_t;

    function automatic pq_step_t pq_on_trigger(pq_t cur);
        pq_step_t r;
        r.nxt = cur;
        r.fwd = 1'b0;
        case (cur)
            PQ_IDLE: begin
                r.nxt = PQ_PEND;
                r.fwd = 1'b1;
            end
            PQ_PEND: r.nxt = PQ_QUEUED;
            default: r.nxt = cur;
        endcase
        return r;
    endfunction

    function automatic pq_step_t pq_on_eoi(pq_t cur);
        pq_step_t r;
        r.nxt = cur;
        r.fwd = 1'b0;
        case (cur)
            PQ_PEND: r.nxt = PQ_IDLE;
            PQ_QUEUED: begin
                r.nxt = PQ_PEND;
                r.fwd = 1'b1;
            end
            default: r.nxt = cur;
        endcase
        return r;
    endfunction

    function automatic pq_step_t pq_on_cmd(mm_cmd_t cmd, pq_t cur);
        pq_step_t r;
        r.nxt = cur;
        r.fwd = 1'b0;
        case (cmd.kind)
            KIND_EOI:  r = pq_on_eoi(cur);
            KIND_TRIG: r = pq_on_trigger(cur);
            KIND_SET:  r.nxt = cmd.set_val;
            default:   r.nxt = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/evsrc_mmio_decode.sv
module evsrc_mmio_decode
    import evsrc_pq_pkg::*;
(
    input  logic            valid,
    input  logic            write,
    input  logic [OP_W-1:0] op,
    output mm_cmd_t         cmd
);
    always_comb begin
        cmd         = '0;
        cmd.kind    = KIND_NONE;
        cmd.is_load = valid && !write;
        if (valid) begin
            if (!write) begin
                if (op[OP_W-1]) begin
                    cmd.kind    = KIND_SET;
                    cmd.set_val = op[1:0];
                end else if (op == OFS_EOI) begin
                    cmd.kind = KIND_EOI;
                end else begin
                    cmd.kind = KIND_PEEK;
                end
            end else begin
                if (op == OFS_EOI)
                    cmd.kind = KIND_EOI;
                else if (op == OFS_TRIG)
                    cmd.kind = KIND_TRIG;
                else
                    cmd.kind = KIND_NONE;
            end
        end
    end
endmodule

// File: rtl/evsrc_pq_cell.sv
module evsrc_pq_cell
    import evsrc_pq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cmd_hit,
    input  mm_cmd_t cmd,
    input  logic    trig_hit,
    output pq_t     state,
    output logic    mm_fwd,
    output logic    hw_fwd
);
    pq_t      state_q;
    pq_step_t after_mm;
    pq_step_t after_tr;

    // port operation first, trigger on its result
    always_comb begin
        after_mm.nxt = state_q;
        after_mm.fwd = 1'b0;
        if (cmd_hit)
            after_mm = pq_on_cmd(cmd, state_q);
        after_tr.nxt = after_mm.nxt;
        after_tr.fwd = 1'b0;
        if (trig_hit)
            after_tr = pq_on_trigger(after_mm.nxt);
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= PQ_OFF;
        else
            state_q <= after_tr.nxt;
    end

    assign state  = state_q;
    assign mm_fwd = after_mm.fwd;
    assign hw_fwd = after_tr.fwd;
endmodule

// File: rtl/evsrc_notify_out.sv
module evsrc_notify_out
    import evsrc_pq_pkg::*;
#(
    parameter int SRC_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_req,
    input  pq_t              rd_val,
    input  logic             hw_fire,
    input  logic [SRC_W-1:0] hw_src,
    input  logic             sw_fire,
    input  logic [SRC_W-1:0] sw_src,
    output logic             rd_valid,
    output pq_t              rd_data,
    output logic             hw_ntf_valid,
    output logic [SRC_W-1:0] hw_ntf_src,
    output logic             sw_ntf_valid,
    output logic [SRC_W-1:0] sw_ntf_src
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid     <= 1'b0;
            rd_data      <= '0;
            hw_ntf_valid <= 1'b0;
            hw_ntf_src   <= '0;
            sw_ntf_valid <= 1'b0;
            sw_ntf_src   <= '0;
        end else begin
            rd_valid     <= rd_req;
            rd_data      <= rd_req ? rd_val : '0;
            hw_ntf_valid <= hw_fire;
            hw_ntf_src   <= hw_fire ? hw_src : '0;
            sw_ntf_valid <= sw_fire;
            sw_ntf_src   <= sw_fire ? sw_src : '0;
        end
    end
endmodule

// File: rtl/evsrc_pq_array.sv
module evsrc_pq_array
    import evsrc_pq_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int SRC_W   = $clog2(NUM_SRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_valid,
    input  logic [SRC_W-1:0] trig_src,
    input  logic             mm_valid,
    input  logic             mm_write,
    input  logic [SRC_W-1:0] mm_src,
    input  logic [2:0]       mm_op,
    output logic             rd_valid,
    output logic [1:0]       rd_data,
    output logic             hw_ntf_valid,
    output logic [SRC_W-1:0] hw_ntf_src,
    output logic             sw_ntf_valid,
    output logic [SRC_W-1:0] sw_ntf_src
);
    mm_cmd_t            cmd;
    pq_t                cell_state [NUM_SRC];
    logic [NUM_SRC-1:0] cell_mm_fwd;
    logic [NUM_SRC-1:0] cell_hw_fwd;

    evsrc_mmio_decode u_dec (
        .valid (mm_valid),
        .write (mm_write),
        .op    (mm_op),
        .cmd   (cmd)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic cmd_hit;
        logic trig_hit;
        assign cmd_hit  = (cmd.kind != KIND_NONE) && (mm_src == SRC_W'(i));
        assign trig_hit = trig_valid && (trig_src == SRC_W'(i));

        evsrc_pq_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .cmd_hit  (cmd_hit),
            .cmd      (cmd),
            .trig_hit (trig_hit),
            .state    (cell_state[i]),
            .mm_fwd   (cell_mm_fwd[i]),
            .hw_fwd   (cell_hw_fwd[i])
        );
    end

    evsrc_notify_out #(.SRC_W(SRC_W)) u_out (
        .clk          (clk),
        .rst          (rst),
        .rd_req       (cmd.is_load),
        .rd_val       (cell_state[mm_src]),
        .hw_fire      (|cell_hw_fwd),
        .hw_src       (trig_src),
        .sw_fire      (|cell_mm_fwd),
        .sw_src       (mm_src),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data),
        .hw_ntf_valid (hw_ntf_valid),
        .hw_ntf_src   (hw_ntf_src),
        .sw_ntf_valid (sw_ntf_valid),
        .sw_ntf_src   (sw_ntf_src)
    );
endmodule

// File: rtl/evsrc_pq_checker.sv
module evsrc_pq_checker #(
    parameter int SRC_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             trig_valid,
    input logic [SRC_W-1:0] trig_src,
    input logic             mm_valid,
    input logic             mm_write,
    input logic [SRC_W-1:0] mm_src,
    input logic [2:0]       mm_op,
    input logic             rd_valid,
    input logic             hw_ntf_valid,
    input logic [SRC_W-1:0] hw_ntf_src,
    input logic             sw_ntf_valid,
    input logic [SRC_W-1:0] sw_ntf_src
);
    AST_LOAD_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        (mm_valid && !mm_write) |=> rd_valid); // R6

    AST_ANSWER_HAS_LOAD: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(mm_valid && !mm_write)); // R6

    AST_HW_LANE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        hw_ntf_valid |-> ($past(trig_valid) && hw_ntf_src == $past(trig_src))); // R2

    AST_SW_LANE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        sw_ntf_valid |-> ($past(mm_valid) && sw_ntf_src == $past(mm_src) &&
                          ($past(mm_op) == 3'b001 ||
                           ($past(mm_write) && $past(mm_op) == 3'b010)))); // R5

    AST_SET_SILENT: assert property (@(posedge clk) disable iff (rst)
        $past(mm_valid && !mm_write && mm_op[2]) |-> !sw_ntf_valid); // R7

    AST_LANES_DISTINCT: assert property (@(posedge clk) disable iff (rst)
        !(hw_ntf_valid && sw_ntf_valid && hw_ntf_src == sw_ntf_src)); // R10

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        (hw_ntf_valid && $past(hw_ntf_valid) && !$past(mm_valid))
            |-> hw_ntf_src != $past(hw_ntf_src)); // R3
endmodule

bind evsrc_pq_array evsrc_pq_checker #(.SRC_W(SRC_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .trig_valid   (trig_valid),
    .trig_src     (trig_src),
    .mm_valid     (mm_valid),
    .mm_write     (mm_write),
    .mm_src       (mm_src),
    .mm_op        (mm_op),
    .rd_valid     (rd_valid),
    .hw_ntf_valid (hw_ntf_valid),
    .hw_ntf_src   (hw_ntf_src),
    .sw_ntf_valid (sw_ntf_valid),
    .sw_ntf_src   (sw_ntf_src)
);

// File: tb/evsrc_pq_array_test.sv
module evsrc_pq_array_test;
    localparam int NSRC = 64;
    localparam int SW   = 6;

    logic          clk = 1'b0;
    logic          rst;
    logic          trig_valid;
    logic [SW-1:0] trig_src;
    logic          mm_valid;
    logic          mm_write;
    logic [SW-1:0] mm_src;
    logic [2:0]    mm_op;
    logic          rd_valid;
    logic [1:0]    rd_data;
    logic          hw_ntf_valid;
    logic [SW-1:0] hw_ntf_src;
    logic          sw_ntf_valid;
    logic [SW-1:0] sw_ntf_src;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    evsrc_pq_array #(.NUM_SRC(NSRC)) uut (
        .clk(clk), .rst(rst),
        .trig_valid(trig_valid), .trig_src(trig_src),
        .mm_valid(mm_valid), .mm_write(mm_write), .mm_src(mm_src), .mm_op(mm_op),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .hw_ntf_valid(hw_ntf_valid), .hw_ntf_src(hw_ntf_src),
        .sw_ntf_valid(sw_ntf_valid), .sw_ntf_src(sw_ntf_src)
    );

    typedef struct packed {
        logic       tv;
        logic [5:0] ts;
        logic       mv;
        logic       mw;
        logic [5:0] ms;
        logic [2:0] op;
        logic       erv;
        logic [1:0] erd;
        logic       ehv;
        logic       esv;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 6'd0,  1'b1, 1'b0, 6'd5,  3'b000, 1'b1, 2'b01, 1'b0, 1'b0, 8'd1},  // R1 reset state
        '{1'b1, 6'd5,  1'b0, 1'b0, 6'd0,  3'b000, 1'b0, 2'b00, 1'b0, 1'b0, 8'd4},  // R4 off source
        '{1'b0, 6'd0,  1'b1, 1'b0, 6'd5,  3'b100, 1'b1, 2'b01, 1'b0, 1'b0, 8'd7},  // R7 set 00
        '{1'b0, 6'd0,  1'b1, 1'b0, 6'd5,  3'b000, 1'b1, 2'b00, 1'b0, 1'b0, 8'd7},  // R7 readback
        '{1'b1, 6'd5,  1'b0, 1'b0, 6'd0,  3'b000, 1'b0, 2'b00, 1'b1, 1'b0, 8'd2},  // R2 forward
        '{1'b1, 6'd5,  1'b0, 1'b0, 6'd0,  3'b000, 1'b0, 2'b00, 1'b0, 1'b0, 8'd3},  // R3 10->11
        '{1'b1, 6'd5,  1'b0, 1'b0, 6'd0,  3'b000, 1'b0, 2'b00, 1'b0, 1'b0, 8'd3},  // R3 11 stays
        '{1'b0, 6'd0,  1'b1, 1'b0, 6'd5,  3'b000, 1'b1, 2'b11, 1'b0, 1'b0, 8'd3},  // R3 readback
        '{1'b0, 6'd0,  1'b1, 1'b0, 6'd5,  3'b001, 1'b1, 2'b11, 1'b0, 1'b1, 8'd5},  // R5 eoi 11
        '{1'b0, 6'd0,  1'b1, 1'b1, 6'd5,  3'b001, 1'b0, 2'b00, 1'b0, 1'b0, 8'd5},  // R5 store eoi 10
        '{1'b0, 6'd0,  1'b1, 1'b0, 6'd5,  3'b000, 1'b1, 2'b00, 1'b0, 1'b0, 8'd5},  // R5 readback
        '{1'b0, 6'd0,  1'b1, 1'b0, 6'd5,  3'b001, 1'b1, 2'b00, 1'b0, 1'b0, 8'd5},  // R5 eoi on 00
        '{1'b0, 6'd0,  1'b1, 1'b1, 6'd5,  3'b010, 1'b0, 2'b00, 1'b0, 1'b1, 8'd8},  // R8 store trigger
        '{1'b0, 6'd0,  1'b1, 1'b1, 6'd5,  3'b100, 1'b0, 2'b00, 1'b0, 1'b0, 8'd9},  // R9 store set
        '{1'b0, 6'd0,  1'b1, 1'b1, 6'd5,  3'b000, 1'b0, 2'b00, 1'b0, 1'b0, 8'd9},  // R9 store get
        '{1'b0, 6'd0,  1'b1, 1'b0, 6'd5,  3'b000, 1'b1, 2'b10, 1'b0, 1'b0, 8'd9},  // R9 readback
        '{1'b0, 6'd0,  1'b1, 1'b0, 6'd9,  3'b100, 1'b1, 2'b01, 1'b0, 1'b0, 8'd7},  // R7 src9 to 00
        '{1'b1, 6'd9,  1'b1, 1'b0, 6'd5,  3'b001, 1'b1, 2'b10, 1'b1, 1'b0, 8'd11}, // R11 two sources
        '{1'b0, 6'd0,  1'b1, 1'b0, 6'd9,  3'b111, 1'b1, 2'b10, 1'b0, 1'b0, 8'd7},  // R7 set 11
        '{1'b1, 6'd5,  1'b1, 1'b1, 6'd9,  3'b001, 1'b0, 2'b00, 1'b1, 1'b1, 8'd11}, // R11 both lanes
        '{1'b1, 6'd5,  1'b1, 1'b1, 6'd5,  3'b001, 1'b0, 2'b00, 1'b1, 1'b0, 8'd10}, // R10 eoi then trig
        '{1'b1, 6'd5,  1'b1, 1'b0, 6'd5,  3'b101, 1'b1, 2'b10, 1'b0, 1'b0, 8'd10}, // R10 off then trig
        '{1'b0, 6'd0,  1'b1, 1'b0, 6'd5,  3'b000, 1'b1, 2'b01, 1'b0, 1'b0, 8'd10}, // R10 readback
        '{1'b0, 6'd0,  1'b1, 1'b0, 6'd63, 3'b100, 1'b1, 2'b01, 1'b0, 1'b0, 8'd7},  // R7 top source
        '{1'b1, 6'd63, 1'b0, 1'b0, 6'd0,  3'b000, 1'b0, 2'b00, 1'b1, 1'b0, 8'd2},  // R2 top source
        '{1'b0, 6'd0,  1'b1, 1'b0, 6'd0,  3'b000, 1'b1, 2'b01, 1'b0, 1'b0, 8'd1},  // R1 untouched src0
        '{1'b0, 6'd0,  1'b1, 1'b0, 6'd63, 3'b011, 1'b1, 2'b10, 1'b0, 1'b0, 8'd9},  // R9 reserved load
        '{1'b0, 6'd0,  1'b1, 1'b0, 6'd63, 3'b010, 1'b1, 2'b10, 1'b0, 1'b0, 8'd9}   // R9 trig-offset load
    };

    task automatic check(input string what, input int req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic tv, input logic [5:0] ts, input logic mv,
                         input logic mw, input logic [5:0] ms, input logic [2:0] op);
        trig_valid = tv; trig_src = ts;
        mm_valid = mv; mm_write = mw; mm_src = ms; mm_op = op;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        drive(1'b0, '0, 1'b0, 1'b0, '0, 3'b000);
    endtask

    initial begin
        trig_valid = 1'b0; trig_src = '0;
        mm_valid = 1'b0; mm_write = 1'b0; mm_src = '0; mm_op = '0;
        rst = 1'b1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        // R1: outputs cleared in reset
        check("rd_valid in reset", 1, int'(rd_valid), 0);
        check("hw lane in reset", 1, int'(hw_ntf_valid), 0);
        check("sw lane in reset", 1, int'(sw_ntf_valid), 0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            drive(VEC[k].tv, VEC[k].ts, VEC[k].mv, VEC[k].mw, VEC[k].ms, VEC[k].op);
            check($sformatf("vec%0d rd_valid", k), VEC[k].req, int'(rd_valid), int'(VEC[k].erv));
            if (VEC[k].erv)
                check($sformatf("vec%0d rd_data", k), VEC[k].req, int'(rd_data), int'(VEC[k].erd));
            check($sformatf("vec%0d hw valid", k), VEC[k].req, int'(hw_ntf_valid), int'(VEC[k].ehv));
            if (VEC[k].ehv)
                check($sformatf("vec%0d hw src", k), VEC[k].req, int'(hw_ntf_src), int'(VEC[k].ts));
            check($sformatf("vec%0d sw valid", k), VEC[k].req, int'(sw_ntf_valid), int'(VEC[k].esv));
            if (VEC[k].esv)
                check($sformatf("vec%0d sw src", k), VEC[k].req, int'(sw_ntf_src), int'(VEC[k].ms));
        end

        // R1: reset mid-run returns a source to off
        drive(1'b0, '0, 1'b1, 1'b0, 6'd7, 3'b100);
        check("src7 set before reset", 1, int'(rd_data), 1);
        rst = 1'b1;
        idle();
        rst = 1'b0;
        drive(1'b0, '0, 1'b1, 1'b0, 6'd7, 3'b000);
        check("src7 after reset", 1, int'(rd_data), 1);
        drive(1'b1, 6'd7, 1'b0, 1'b0, '0, 3'b000);
        check("trigger after reset", 1, int'(hw_ntf_valid), 0);
        idle();
        check("quiet after idle", 1, int'(hw_ntf_valid | sw_ntf_valid | rd_valid), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule